// File: doc/BRIEF.md
# Standby and Wake-up Controller

This block puts a small controller core into standby when a halt instruction is decoded, and brings it back when a selected condition occurs. A halt strobe comes with a wake configuration taken from the instruction operand: a 2-bit source code and a level bit. The oscillator-stop control bit then picks one of two standby flavours. In the first, the core is stalled and the clock keeps running. In the second, the block also asks the oscillator to stop.

If the program timer is still counting when an oscillator stop is requested, the core stalls at once. The oscillator request is held back until the count has finished. The block runs on an always-on clock.

External pin levels pass through a two-flop synchroniser before they are compared with the wanted level. A wake event releases the stall, enables the oscillator again and gives a one-cycle pulse. Core registers and data memory are never touched by this block, so execution simply goes on at the next instruction.

Top module: `standby_ctrl`

## Requirements
- R1: After reset, stall_o is 0, osc_en_o is 1 and wake_o is 0.
- R2: When halt_i is high while stall_o is low, stall_o is 1 after the next clock edge. With osc_stop_i = 0, osc_en_o stays 1 for the whole standby.
- R3: If halt_i arrives with osc_stop_i = 1 while tmr_run_i = 0, osc_en_o goes to 0 on the same edge that raises stall_o.
- R4: If halt_i arrives with osc_stop_i = 1 while tmr_run_i = 1, stall_o rises at once but osc_en_o stays 1. osc_en_o falls on the first edge that samples tmr_run_i = 0.
- R5: Source code 2'b00 (with sin_sel_i = 1) wakes when the synchronised sin_i equals the level bit (0 = low, 1 = high). A pin change is seen as a wake on the third clock edge after it.
- R6: Source code 2'b01 wakes when any bit of kio_i matches the level bit. This only applies while kio_out_i = 0 (input mode). With kio_out_i = 1 this source never wakes.
- R7: Source code 2'b10 wakes when any bit of ki_i matches the level bit.
- R8: Source code 2'b11 wakes on tmr_done_i = 1, and the level bit has no effect. The wake shows one edge after tmr_done_i is sampled high.
- R9: Source code 2'b00 with sin_sel_i = 0 (shift input recirculates the accumulator MSB) wakes on the first edge after standby is entered, whatever sin_i is.
- R10: On a wake, stall_o goes to 0 and osc_en_o goes to 1 on the same edge that raises wake_o. wake_o is high for exactly one cycle.
- R11: The source code, the level bit and osc_stop_i are captured at the halt strobe. Changing them during standby has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Halt instruction strobe, one cycle |
| src_sel_i | input | 2 | Wake source code from the operand |
| level_i | input | 1 | Wake level for pin sources |
| osc_stop_i | input | 1 | 1 = stop oscillator in standby |
| kio_out_i | input | 1 | Key I/O port direction, 1 = output |
| sin_sel_i | input | 1 | 1 = serial pin feeds shift, 0 = MSB recirculates |
| sin_i | input | 1 | Serial input pin |
| kio_i | input | KIO_W | Key I/O pin levels |
| ki_i | input | KI_W | Key input pin levels |
| tmr_done_i | input | 1 | Timer has reached zero |
| tmr_run_i | input | 1 | Timer is counting |
| stall_o | output | 1 | Core stall |
| osc_en_o | output | 1 | Oscillator enable |
| wake_o | output | 1 | One-cycle wake pulse |

## Verification
The bench targets the "any pin matches" rule at both level polarities. A design that used an AND instead of an OR over the group would miss a wake on an all-low port with a single high pin.

It also checks that the key port in output mode never wakes. It checks the immediate release when the shift input recirculates; a design missing that release would hang in standby.

It checks the deferred oscillator stop. A design that dropped osc_en_o at once would cut the clock while the timer still counts.

It checks that the operand is captured at the strobe. A design that read the live inputs would wake early when the level bit is flipped during standby.

// File: rtl/standby_pkg.sv
package standby_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_HALT      = 2'd1,
        ST_STOP_WAIT = 2'd2,
        ST_STOP      = 2'd3
    } sb_state_e;

    typedef enum logic [1:0] {
        SRC_SIN = 2'b00,
        SRC_KIO = 2'b01,
        SRC_KI  = 2'b10,
        SRC_TMR = 2'b11
    } wake_src_e;

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] pin_o
);
    logic [STAGES-1:0][W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_i;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign pin_o = chain_q[STAGES-1];
endmodule

// File: rtl/wake_detect.sv
module wake_detect
    import standby_pkg::*;
#(
    parameter int KIO_W = 8,
    parameter int KI_W  = 4
) (
    input  wake_src_e        src_i,
    input  logic             level_i,
    input  logic             kio_out_i,
    input  logic             sin_sel_i,
    input  logic             sin_s_i,
    input  logic [KIO_W-1:0] kio_s_i,
    input  logic [KI_W-1:0]  ki_s_i,
    input  logic             tmr_done_i,
    output logic             hit_o
);
    logic kio_match, ki_match, sin_match;

    // any pin of a group at the wanted level
    assign kio_match = level_i ? (|kio_s_i) : ~(&kio_s_i);
    assign ki_match  = level_i ? (|ki_s_i)  : ~(&ki_s_i);
    assign sin_match = (sin_s_i == level_i);

    always_comb begin
        unique case (src_i)
            SRC_SIN: hit_o = sin_sel_i ? sin_match : 1'b1;
            SRC_KIO: hit_o = kio_match & ~kio_out_i;
            SRC_KI:  hit_o = ki_match;
            default: hit_o = tmr_done_i;
        endcase
    end
endmodule

// File: rtl/standby_fsm.sv
module standby_fsm
    import standby_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      halt_i,
    input  logic [1:0] src_sel_i,
    input  logic      level_i,
    input  logic      osc_stop_i,
    input  logic      tmr_run_i,
    input  logic      hit_i,
    output wake_src_e src_o,
    output logic      level_o,
    output logic      stall_o,
    output logic      osc_en_o,
    output logic      wake_o
);
    typedef struct packed {
        sb_state_e state;
        wake_src_e src;
        logic      lvl;
        logic      stall;
        logic      osc_en;
        logic      wake;
    } fsm_t;

    localparam fsm_t FSM_RST = '{
        state:  ST_RUN,
        src:    SRC_SIN,
        lvl:    1'b0,
        stall:  1'b0,
        osc_en: 1'b1,
        wake:   1'b0
    };

    fsm_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.wake = 1'b0;
        unique case (r_q.state)
            ST_RUN: begin
                if (halt_i) begin
                    r_d.src   = wake_src_e'(src_sel_i);
                    r_d.lvl   = level_i;
                    r_d.stall = 1'b1;
                    if (!osc_stop_i) begin
                        r_d.state = ST_HALT;
                    end else if (tmr_run_i) begin
                        r_d.state = ST_STOP_WAIT;
                    end else begin
                        r_d.state  = ST_STOP;
                        r_d.osc_en = 1'b0;
                    end
                end
            end
            default: begin
                if (hit_i) begin
                    r_d.state  = ST_RUN;
                    r_d.stall  = 1'b0;
                    r_d.osc_en = 1'b1;
                    r_d.wake   = 1'b1;
                end else if (r_q.state == ST_STOP_WAIT && !tmr_run_i) begin
                    r_d.state  = ST_STOP;
                    r_d.osc_en = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= FSM_RST;
        end else begin
            r_q <= r_d;
        end
    end

    assign src_o    = r_q.src;
    assign level_o  = r_q.lvl;
    assign stall_o  = r_q.stall;
    assign osc_en_o = r_q.osc_en;
    assign wake_o   = r_q.wake;
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl
    import standby_pkg::*;
#(
    parameter int KIO_W       = 8,
    parameter int KI_W        = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    input  logic [1:0]       src_sel_i,
    input  logic             level_i,
    input  logic             osc_stop_i,
    input  logic             kio_out_i,
    input  logic             sin_sel_i,
    input  logic             sin_i,
    input  logic [KIO_W-1:0] kio_i,
    input  logic [KI_W-1:0]  ki_i,
    input  logic             tmr_done_i,
    input  logic             tmr_run_i,
    output logic             stall_o,
    output logic             osc_en_o,
    output logic             wake_o
);
    localparam int PIN_W = 1 + KIO_W + KI_W;

    logic [PIN_W-1:0] pins_raw, pins_s;
    logic             sin_s;
    logic [KIO_W-1:0] kio_s;
    logic [KI_W-1:0]  ki_s;
    wake_src_e        src_q;
    logic             lvl_q;
    logic             hit;

    assign pins_raw = {sin_i, kio_i, ki_i};
    assign {sin_s, kio_s, ki_s} = pins_s;

    pin_sync #(.W(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (pins_raw),
        .pin_o (pins_s)
    );

    wake_detect #(.KIO_W(KIO_W), .KI_W(KI_W)) u_det (
        .src_i      (src_q),
        .level_i    (lvl_q),
        .kio_out_i  (kio_out_i),
        .sin_sel_i  (sin_sel_i),
        .sin_s_i    (sin_s),
        .kio_s_i    (kio_s),
        .ki_s_i     (ki_s),
        .tmr_done_i (tmr_done_i),
        .hit_o      (hit)
    );

    standby_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_i     (halt_i),
        .src_sel_i  (src_sel_i),
        .level_i    (level_i),
        .osc_stop_i (osc_stop_i),
        .tmr_run_i  (tmr_run_i),
        .hit_i      (hit),
        .src_o      (src_q),
        .level_o    (lvl_q),
        .stall_o    (stall_o),
        .osc_en_o   (osc_en_o),
        .wake_o     (wake_o)
    );
endmodule

// File: rtl/standby_ctrl_chk.sv
module standby_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic halt_i,
    input logic osc_stop_i,
    input logic tmr_run_i,
    input logic stall_o,
    input logic osc_en_o,
    input logic wake_o
);
    a_r2_halt_stalls: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !stall_o) |=> stall_o);

    a_r3_stop_now: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !stall_o && osc_stop_i && !tmr_run_i) |=> !osc_en_o);

    a_r4_stop_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_i && !stall_o && osc_stop_i && tmr_run_i) |=> osc_en_o);

    a_r4_osc_off_only_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en_o |-> stall_o);

    a_r10_wake_single: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |=> !wake_o);

    a_r10_wake_running: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (!stall_o && osc_en_o));

    a_r10_wake_from_standby: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wake_o) |-> $past(stall_o));
endmodule

bind standby_ctrl standby_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_i     (halt_i),
    .osc_stop_i (osc_stop_i),
    .tmr_run_i  (tmr_run_i),
    .stall_o    (stall_o),
    .osc_en_o   (osc_en_o),
    .wake_o     (wake_o)
);

// File: tb/standby_ctrl_tb.sv
module standby_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_i = 1'b0;
    logic [1:0] src_sel_i = 2'b00;
    logic       level_i = 1'b0;
    logic       osc_stop_i = 1'b0;
    logic       kio_out_i = 1'b0;
    logic       sin_sel_i = 1'b1;
    logic       sin_i = 1'b0;
    logic [7:0] kio_i = 8'h00;
    logic [3:0] ki_i = 4'h0;
    logic       tmr_done_i = 1'b0;
    logic       tmr_run_i = 1'b0;
    logic       stall_o, osc_en_o, wake_o;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    standby_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .halt_i(halt_i), .src_sel_i(src_sel_i),
        .level_i(level_i), .osc_stop_i(osc_stop_i), .kio_out_i(kio_out_i),
        .sin_sel_i(sin_sel_i), .sin_i(sin_i), .kio_i(kio_i), .ki_i(ki_i),
        .tmr_done_i(tmr_done_i), .tmr_run_i(tmr_run_i),
        .stall_o(stall_o), .osc_en_o(osc_en_o), .wake_o(wake_o)
    );

    typedef struct packed {
        logic [1:0] sel;
        logic       lvl;
        logic       osc;
        logic       kout;
        logic       ssel;
        logic       sin;
        logic [7:0] kio;
        logic [3:0] ki;
        logic       tdone;
        logic       exp;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h00, 4'h0, 1'b0, 1'b1}, // R5 high
        '{2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 4'hF, 1'b0, 1'b0}, // R5 no match
        '{2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 4'h0, 1'b0, 1'b1}, // R5 low
        '{2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 4'h0, 1'b0, 1'b1}, // R9
        '{2'b01, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h10, 4'h0, 1'b0, 1'b1}, // R6 one high
        '{2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 4'hF, 1'b1, 1'b0}, // R6 none high
        '{2'b01, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'hFF, 4'h0, 1'b0, 1'b0}, // R6 none low
        '{2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFE, 4'hF, 1'b0, 1'b1}, // R6 one low
        '{2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'hFF, 4'h0, 1'b0, 1'b0}, // R6 output mode
        '{2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hFF, 4'h4, 1'b0, 1'b1}, // R7 one high
        '{2'b10, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 4'hF, 1'b0, 1'b0}, // R7 none low
        '{2'b10, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'hFF, 4'h7, 1'b0, 1'b1}, // R7 one low
        '{2'b11, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 4'h0, 1'b1, 1'b1}, // R8 done
        '{2'b11, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'hFF, 4'hF, 1'b0, 1'b0}  // R8 not done
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        halt_i = 1'b0;
        step(1);
        rst_n = 1'b1;
    endtask

    task automatic halt(input logic [1:0] sel, input logic lvl, input logic osc);
        src_sel_i  = sel;
        level_i    = lvl;
        osc_stop_i = osc;
        halt_i     = 1'b1;
        step(1);
        halt_i     = 1'b0;
    endtask

    function automatic string tag_of(input vec_t v);
        if (v.sel == 2'b00) return v.ssel ? "R5" : "R9";
        if (v.sel == 2'b01) return "R6";
        if (v.sel == 2'b10) return "R7";
        return "R8";
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            summary();
        end
    end

    initial begin
        int wakes;
        step(2);
        // R1 reset state
        chk("R1 stall", stall_o, 0);
        chk("R1 osc_en", osc_en_o, 1);
        chk("R1 wake", wake_o, 0);
        rst_n = 1'b1;
        step(1);

        for (int i = 0; i < NV; i++) begin
            do_reset();
            kio_out_i  = VECS[i].kout;
            sin_sel_i  = VECS[i].ssel;
            sin_i      = VECS[i].sin;
            kio_i      = VECS[i].kio;
            ki_i       = VECS[i].ki;
            tmr_done_i = VECS[i].tdone;
            tmr_run_i  = 1'b0;
            step(3);
            halt(VECS[i].sel, VECS[i].lvl, VECS[i].osc);
            chk("R2 stall after halt", stall_o, 1);
            chk("R3 osc_en at entry", osc_en_o, !VECS[i].osc);
            wakes = 0;
            for (int k = 0; k < 5; k++) begin
                step(1);
                if (wake_o) wakes++;
            end
            chk(tag_of(VECS[i]), stall_o, !VECS[i].exp);
            chk("R10 wake pulse count", wakes, VECS[i].exp);
            chk("R10 osc_en after", osc_en_o, VECS[i].exp | !VECS[i].osc);
        end

        // R4: deferred oscillator stop, then pin wake with latency (R5, R10)
        do_reset();
        sin_sel_i = 1'b1; sin_i = 1'b0; kio_out_i = 1'b0;
        tmr_done_i = 1'b0; tmr_run_i = 1'b1;
        step(3);
        halt(2'b00, 1'b1, 1'b1);
        chk("R4 stall at once", stall_o, 1);
        chk("R4 osc held", osc_en_o, 1);
        step(4);
        chk("R4 osc held while counting", osc_en_o, 1);
        tmr_run_i = 1'b0;
        step(1);
        chk("R4 osc off after count end", osc_en_o, 0);
        sin_i = 1'b1;
        step(2);
        chk("R5 sync latency", stall_o, 1);
        step(1);
        chk("R10 wake", wake_o, 1);
        chk("R10 stall cleared", stall_o, 0);
        chk("R10 osc back", osc_en_o, 1);
        step(1);
        chk("R10 pulse ends", wake_o, 0);

        // R11: operand captured at the strobe
        do_reset();
        sin_sel_i = 1'b1; sin_i = 1'b0; tmr_done_i = 1'b0; tmr_run_i = 1'b0;
        step(3);
        halt(2'b00, 1'b1, 1'b0);
        src_sel_i = 2'b11; level_i = 1'b0; osc_stop_i = 1'b1; tmr_done_i = 1'b1;
        step(5);
        chk("R11 still stalled", stall_o, 1);
        chk("R11 osc unchanged", osc_en_o, 1);
        sin_i = 1'b1;
        step(3);
        chk("R11 wake on captured source", wake_o, 1);

        done = 1'b1;
        summary();
    end
endmodule